// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block sits on the master side of a management bus and turns one request (target device address, register address, read/write flag, write data) into the short series of clause-22 transactions needed to reach a register behind a command/data window. The switch-like target exposes only two registers at its own bus address: a command register and a data register. The sequencer first waits for the command register's busy bit to clear. For a write it then loads the data register and issues a command word. For a read it issues the command word directly. It waits for busy to clear again and, for a read, fetches the result from the data register.

When the configured chip address is zero the target answers every bus address itself, so the sequencer skips the window and makes one direct access to the requested device and register. Each busy-wait phase is bounded by a retry limit; a target that stays busy past it ends the request with an error. The management bus is abstract: one access per cycle, with read data returned combinationally in the cycle of the access.

Top module: `mgmt_window_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and no bus access is made (mb_en is 0).
- R2: A request is taken only on a cycle where req_valid and req_ready are both 1. req_ready stays 0 from acceptance until the done cycle. Request inputs presented meanwhile change neither the bus activity nor the result.
- R3: With chip_addr equal to 0, a request makes exactly one bus access, to mb_phy = req_dev and mb_reg = req_reg (writing req_wdata for a write). done follows one cycle after that access, with rdata equal to the bus data for a read and 0 for a write.
- R4: With chip_addr nonzero, every bus access goes to mb_phy = chip_addr. The command register is at mb_reg 0 and the data register is at mb_reg 1.
- R5: The command word has bit 15 = 1 (start/busy), bit 12 = 1 (clause-22), bits 14:13 = 0, bits 11:10 = 2 for a read or 1 for a write, bits 9:5 = req_dev and bits 4:0 = req_reg.
- R6: Before a command is issued, the command register is read repeatedly until a read returns bit 15 = 0.
- R7: An indirect write runs in this order: busy wait, write req_wdata to the data register, write the command word, busy wait.
- R8: An indirect read runs in this order: busy wait, write the command word, busy wait, one read of the data register. The value of that read is returned on rdata.
- R9: Within a busy-wait phase, the read that finds busy set for the (retry_limit+1)-th time ends the request. That cycle is followed by done with err = 1 and rdata = 0, and no further bus access is made for that request.
- R10: done is a single-cycle pulse. err is 0 on a request that completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_addr | input | 5 | Target bus address; 0 selects direct mode |
| retry_limit | input | RETRY_W | Busy reads tolerated per wait phase before a timeout |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Internal device address of the target register |
| req_reg | input | 5 | Register address within that device |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rdata | output | 16 | Read result, valid with done |
| mb_en | output | 1 | Management access this cycle |
| mb_we | output | 1 | 1 = write access |
| mb_phy | output | 5 | Bus (PHY) address of the access |
| mb_reg | output | 5 | Register address of the access |
| mb_wdata | output | 16 | Write data of the access |
| mb_rdata | input | 16 | Read data returned in the access cycle |

## Verification
The in-module assertions check several properties on every cycle. Window accesses never leave the chip address or the two window registers. Every command write carries a well-formed clause-22 word. A write command is always directly preceded by the data-register load. A data-register read always directly follows a poll that saw busy clear. A timeout never returns data, and done never lasts two cycles. Other behaviour is shown only by the bench's target model, which holds busy for a chosen number of polls before and after the command. Those scenarios cover the exact number of polls, the point where the retry limit turns a wait into a timeout, the value returned by a read through the window, and that inputs changed during a busy request are ignored.

// File: rtl/mgmt_window_seq.sv
module mgmt_window_seq #(
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4:0]         chip_addr,
  input  logic [RETRY_W-1:0] retry_limit,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [4:0]         req_dev,
  input  logic [4:0]         req_reg,
  input  logic [15:0]        req_wdata,
  output logic               done,
  output logic               err,
  output logic [15:0]        rdata,
  output logic               mb_en,
  output logic               mb_we,
  output logic [4:0]         mb_phy,
  output logic [4:0]         mb_reg,
  output logic [15:0]        mb_wdata,
  input  logic [15:0]        mb_rdata
);

  localparam logic [4:0] CMD_REG  = 5'd0;
  localparam logic [4:0] DATA_REG = 5'd1;
  localparam logic [1:0] OP_RD    = 2'd2;
  localparam logic [1:0] OP_WR    = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE, S_DIRECT, S_PRE, S_WDAT, S_CMD, S_POST, S_RDAT
  } st_t;

  st_t                st;
  logic               wr_q;
  logic [4:0]         dev_q, reg_q, chip_q;
  logic [15:0]        wd_q;
  logic [RETRY_W-1:0] tries;

  wire        busy_rd = mb_rdata[15];
  wire        give_up = busy_rd && (tries == retry_limit);
  wire [15:0] cmd_word = {1'b1, 2'b00, 1'b1, (wr_q ? OP_WR : OP_RD), dev_q, reg_q};

  assign req_ready = (st == S_IDLE);
  assign mb_en     = (st != S_IDLE);
  assign mb_we     = (st == S_DIRECT && wr_q) || st == S_WDAT || st == S_CMD;
  assign mb_phy    = (st == S_DIRECT) ? dev_q : chip_q;
  assign mb_reg    = (st == S_DIRECT) ? reg_q :
                     (st == S_WDAT || st == S_RDAT) ? DATA_REG : CMD_REG;
  assign mb_wdata  = (st == S_CMD) ? cmd_word : wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wr_q   <= 1'b0;
      dev_q  <= '0;
      reg_q  <= '0;
      chip_q <= '0;
      wd_q   <= '0;
      tries  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q   <= req_write;
          dev_q  <= req_dev;
          reg_q  <= req_reg;
          wd_q   <= req_wdata;
          chip_q <= chip_addr;
          tries  <= '0;
          st     <= (chip_addr == 5'd0) ? S_DIRECT : S_PRE;
        end
        S_DIRECT: begin
          done  <= 1'b1;
          err   <= 1'b0;
          rdata <= wr_q ? 16'h0 : mb_rdata;
          st    <= S_IDLE;
        end
        S_PRE: begin
          if (!busy_rd) begin
            tries <= '0;
            st    <= wr_q ? S_WDAT : S_CMD;
          end else if (give_up) begin
            done  <= 1'b1;
            err   <= 1'b1;
            rdata <= '0;
            st    <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;
          end
        end
        S_WDAT: st <= S_CMD;
        S_CMD: begin
          tries <= '0;
          st    <= S_POST;
        end
        S_POST: begin
          if (!busy_rd) begin
            if (wr_q) begin
              done  <= 1'b1;
              err   <= 1'b0;
              rdata <= '0;
              st    <= S_IDLE;
            end else begin
              st <= S_RDAT;
            end
          end else if (give_up) begin
            done  <= 1'b1;
            err   <= 1'b1;
            rdata <= '0;
            st    <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;
          end
        end
        S_RDAT: begin
          done  <= 1'b1;
          err   <= 1'b0;
          rdata <= mb_rdata;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  accept_starts_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mb_en && !req_ready));

  // R4
  window_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_en && chip_q != 5'd0) |-> (mb_phy == chip_q && mb_reg <= DATA_REG));

  // R5
  cmd_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_en && mb_we && chip_q != 5'd0 && mb_reg == CMD_REG) |->
      (mb_wdata[15:12] == 4'b1001 && (mb_wdata[11:10] == OP_RD || mb_wdata[11:10] == OP_WR)));

  // R7
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_en && mb_we && chip_q != 5'd0 && mb_reg == CMD_REG && mb_wdata[11:10] == OP_WR) |->
      $past(mb_en && mb_we && mb_reg == DATA_REG));

  // R8
  rd_after_idle_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_en && !mb_we && chip_q != 5'd0 && mb_reg == DATA_REG) |->
      $past(mb_en && !mb_we && mb_reg == CMD_REG && !mb_rdata[15]));

  // R9
  timeout_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rdata == 16'h0));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/mgmt_window_seq_bench.sv
module mgmt_window_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] chip_addr = 5'd0;
  logic [RW-1:0] retry_limit = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [4:0] req_dev = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic done, err;
  logic [15:0] rdata;
  logic mb_en, mb_we;
  logic [4:0] mb_phy, mb_reg;
  logic [15:0] mb_wdata, mb_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_window_seq #(.RETRY_W(RW)) u_mgmt_window_seq (
    .clk(clk), .rst_n(rst_n), .chip_addr(chip_addr), .retry_limit(retry_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
    .done(done), .err(err), .rdata(rdata),
    .mb_en(mb_en), .mb_we(mb_we), .mb_phy(mb_phy), .mb_reg(mb_reg),
    .mb_wdata(mb_wdata), .mb_rdata(mb_rdata));

  int checks = 0, failures = 0;

  // target model: register array behind a command/data window
  logic [15:0] mem [1024];
  logic [15:0] dreg;
  int busy_cnt;
  int pre_busy = 0, post_busy = 0;
  logic        lg_we  [256];
  logic [4:0]  lg_phy [256];
  logic [4:0]  lg_reg [256];
  logic [15:0] lg_wd  [256];
  int lg_n;

  function automatic logic [15:0] init_val(int i);
    return 16'((i * 2654 + 16'h3c5a) ^ (i << 7));
  endfunction

  always_comb begin
    if (chip_addr == 5'd0) mb_rdata = mem[{mb_phy, mb_reg}];
    else if (mb_phy == chip_addr && mb_reg == 5'd0) mb_rdata = {busy_cnt != 0, 15'h0};
    else if (mb_phy == chip_addr && mb_reg == 5'd1) mb_rdata = dreg;
    else mb_rdata = 16'hdead;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
      dreg <= '0;
      busy_cnt <= 0;
      lg_n <= 0;
    end else begin
      if (req_valid && req_ready) busy_cnt <= pre_busy;
      if (mb_en) begin
        lg_we[lg_n % 256]  <= mb_we;
        lg_phy[lg_n % 256] <= mb_phy;
        lg_reg[lg_n % 256] <= mb_reg;
        lg_wd[lg_n % 256]  <= mb_wdata;
        lg_n <= lg_n + 1;
        if (chip_addr == 5'd0) begin
          if (mb_we) mem[{mb_phy, mb_reg}] <= mb_wdata;
        end else if (mb_phy == chip_addr) begin
          if (mb_reg == 5'd0) begin
            if (mb_we) begin
              busy_cnt <= post_busy;
              if (mb_wdata[11:10] == 2'd1) mem[mb_wdata[9:0]] <= dreg;
              else dreg <= mem[mb_wdata[9:0]];
            end else if (busy_cnt > 0) begin
              busy_cnt <= busy_cnt - 1;
            end
          end else if (mb_reg == 5'd1 && mb_we) begin
            dreg <= mb_wdata;
          end
        end
      end
    end
  end

  logic [15:0] exp_mem [1024];
  logic        e_we  [64];
  logic [4:0]  e_phy [64];
  logic [4:0]  e_reg [64];
  logic [15:0] e_wd  [64];
  logic        e_cmp [64];
  string       e_tag [64];
  int e_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic add_op(input logic we, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input logic cmp, input string tag);
    e_we[e_n] = we; e_phy[e_n] = phy; e_reg[e_n] = rg;
    e_wd[e_n] = wd; e_cmp[e_n] = cmp; e_tag[e_n] = tag;
    e_n++;
  endtask

  task automatic do_req(input logic wr, input logic [4:0] dev, input logic [4:0] rg,
                        input logic [15:0] wd, input int pre, input int post,
                        input bit hold);
    int lim, n1, n2, start, cyc;
    logic exp_err;
    logic [15:0] exp_rd, cw;
    lim = int'(retry_limit);
    e_n = 0; exp_err = 1'b0; exp_rd = 16'h0;
    cw = 16'h9000 | (wr ? 16'h0400 : 16'h0800) | {6'h0, dev, rg};
    if (chip_addr == 5'd0) begin
      add_op(wr, dev, rg, wd, wr, "R3");
      if (wr) exp_mem[{dev, rg}] = wd; else exp_rd = exp_mem[{dev, rg}];
    end else begin
      n1 = (pre > lim) ? lim + 1 : pre + 1;
      for (int i = 0; i < n1; i++) add_op(1'b0, chip_addr, 5'd0, 16'h0, 1'b0, "R6");
      if (pre > lim) exp_err = 1'b1;
      else begin
        if (wr) add_op(1'b1, chip_addr, 5'd1, wd, 1'b1, "R7");
        add_op(1'b1, chip_addr, 5'd0, cw, 1'b1, "R5");
        if (wr) exp_mem[{dev, rg}] = wd;
        n2 = (post > lim) ? lim + 1 : post + 1;
        for (int i = 0; i < n2; i++) add_op(1'b0, chip_addr, 5'd0, 16'h0, 1'b0, wr ? "R7" : "R8");
        if (post > lim) exp_err = 1'b1;
        else if (!wr) begin
          add_op(1'b0, chip_addr, 5'd1, 16'h0, 1'b0, "R8");
          exp_rd = exp_mem[{dev, rg}];
        end
      end
    end
    pre_busy = pre; post_busy = post;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    req_write = wr; req_dev = dev; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
    start = lg_n;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    else begin
      req_write = ~wr; req_dev = dev ^ 5'h15; req_reg = rg ^ 5'h0a; req_wdata = ~wd;
    end
    cyc = 0;
    while (!done && cyc < 200) begin
      if (hold) chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(done == 1'b1, "R10", "done seen", done, 1);
    chk(err == exp_err, exp_err ? "R9" : "R10", "err", err, exp_err);
    chk(rdata == exp_rd, exp_err ? "R9" : (chip_addr == 0 ? "R3" : "R8"), "rdata", rdata, exp_rd);
    chk(lg_n - start == e_n, exp_err ? "R9" : "R6", "bus access count", lg_n - start, e_n);
    if (lg_n - start == e_n)
      for (int k = 0; k < e_n; k++) begin
        int j;
        j = (start + k) % 256;
        chk(lg_we[j] == e_we[k] && lg_phy[j] == e_phy[k] && lg_reg[j] == e_reg[k] &&
            (!e_cmp[k] || lg_wd[j] == e_wd[k]),
            (e_phy[k] == chip_addr && chip_addr != 0 && !e_cmp[k]) ? e_tag[k] :
              (chip_addr == 0 ? "R3" : (e_reg[k] == 5'd0 && e_cmp[k] ? "R5" : "R4")),
            $sformatf("access %0d we/phy/reg/wd", k),
            {lg_we[j], lg_phy[j], lg_reg[j], lg_wd[j]},
            {e_we[k], e_phy[k], e_reg[k], e_wd[k]});
      end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single pulse", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(mb_en == 1'b0, "R1", "bus idle in reset", mb_en, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mb_en == 1'b0 && req_ready == 1'b1, "R1", "idle after reset", {mb_en, req_ready}, 1);

    // R3: direct mode sweep
    chip_addr = 5'd0;
    retry_limit = 4'd2;
    for (int r = 0; r < 32; r++) do_req(1'b0, 5'd3, 5'(r), 16'h0, 0, 0, 0);
    for (int r = 0; r < 32; r++) do_req(1'b1, 5'd9, 5'(r), 16'(r * 4111 + 5), 0, 0, r % 4 == 0);
    for (int r = 0; r < 32; r += 3) do_req(1'b0, 5'd9, 5'(r), 16'h0, 0, 0, 0);

    // R4..R9: indirect mode, sweep of busy lengths around the retry limit
    chip_addr = 5'd16;
    retry_limit = 4'd3;
    for (int p = 0; p < 6; p++)
      for (int q = 0; q < 6; q++) begin
        do_req(1'b1, 5'(p * 5 + q), 5'(q * 7 + p), 16'(p * 997 + q * 131 + 1), p, q, (p + q) % 5 == 0);
        do_req(1'b0, 5'(p * 5 + q), 5'(q * 7 + p), 16'h0, q, p, (p + q) % 3 == 0);
      end

    // R9: zero retry limit, any busy read times out
    retry_limit = 4'd0;
    do_req(1'b0, 5'd1, 5'd2, 16'h0, 1, 0, 0);
    do_req(1'b1, 5'd1, 5'd2, 16'h1234, 0, 1, 0);
    do_req(1'b0, 5'd1, 5'd2, 16'h0, 0, 0, 0);

    // R4: another chip address, maximum limit
    chip_addr = 5'd27;
    retry_limit = 4'd15;
    do_req(1'b1, 5'd31, 5'd31, 16'hbeef, 15, 14, 1);
    do_req(1'b0, 5'd31, 5'd31, 16'h0, 7, 15, 0);
    do_req(1'b0, 5'd0, 5'd0, 16'h0, 16, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule